// File: doc/BRIEF.md
# First-Fit Contiguous Page Allocator

This block hands out runs of contiguous pages from a 128-page buffer memory, each page holding 16 words. A client asks for a run by giving its length in words (16, 32, 64 or 128, meaning 1, 2, 4 or 8 pages). The allocator then walks the occupancy bitmap from page 0 upward, one candidate start position per clock. It grants the lowest start whose pages are all free, marks those pages used, and reports the start page. If no position fits before the run would run past the last page, it reports an out-of-space error and leaves the bitmap untouched.

A separate release port frees a run, given its start page and a 2-bit size code. The release is applied on the clock edge at which it is presented, even while a search is running, so later candidates of that search see the freed pages. The first four pages are reserved for configuration from reset onward. They are never granted and never freed. Each request ends in a one-cycle completion pulse that carries either the start page or an error code.

Top module: `pgalloc_top`

## Requirements
- R1: After reset the block is not busy, gives no completion pulse, and every page except the reserved ones is free, so the first 1-page request is granted page 4.
- R2: A request length of 16, 32, 64 or 128 words asks for 1, 2, 4 or 8 pages. Any other length completes in the cycle after the request with error code 2'b01, and no page changes state.
- R3: The grant is the lowest start page whose whole run is free. Starts are not aligned to the run size.
- R4: The search tests one start position per cycle, beginning at page 0. A grant at page P is reported with the completion pulse P+2 sampling cycles after the request is presented, and busy is high until then.
- R5: When every start position up to the one where the run would pass page 127 has been tried without success, the request completes with error code 2'b10, and no page changes state.
- R6: A granted run is marked used, so no later grant overlaps it until it is released. A successful completion carries error code 2'b00.
- R7: Pages 0 to 3 are never granted, and a release that covers them leaves them used.
- R8: A release frees exactly the pages from its start page up to start + 2^code - 1 (code 0..3 for 1..8 pages) and no others.
- R9: A request presented while a search is in progress is ignored: it produces no completion and allocates nothing.
- R10: A release presented while a search is running is visible to the next start position that search tests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Request strobe, taken when idle |
| req_words_i | input | 8 | Requested length in words |
| busy_o | output | 1 | Search in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 2 | Completion code: 00 granted, 01 bad length, 10 no space |
| start_page_o | output | 7 | Granted start page, valid with done_o and err_o = 00 |
| rel_i | input | 1 | Release strobe |
| rel_page_i | input | 7 | Start page of the run to free |
| rel_code_i | input | 2 | Size code of the run to free |

## Verification
The hardest state to reach is a buffer with no room left. The stimulus fills all 124 usable pages with a chain of 8-page grants, then a 4-page and a 2-page grant, then asks for one more page. That request must walk every start position, including the one past the end, before it fails. A single-page hole is then opened to show that a 2-page request still fails while a 1-page request lands in the hole. A release timed to the second cycle of a running search shows that the freed pages are found by the same search.

// File: rtl/pgalloc_pkg.sv
package pgalloc_pkg;

  typedef enum logic [1:0] {
    PGA_OK      = 2'b00,
    PGA_BADLEN  = 2'b01,
    PGA_NOSPACE = 2'b10
  } pga_err_e;

  typedef enum logic {
    PGA_IDLE   = 1'b0,
    PGA_SEARCH = 1'b1
  } pga_state_e;

endpackage

// File: rtl/pgalloc_run_mask.sv
module pgalloc_run_mask #(
  parameter int NUM_PAGES = 128,
  parameter int CODE_W    = 2,
  parameter int SUM_W     = 8
) (
  input  logic [SUM_W-1:0]     start_i,
  input  logic [CODE_W-1:0]    code_i,
  output logic [NUM_PAGES-1:0] mask_o
);

  logic [SUM_W-1:0] end_excl;

  assign end_excl = start_i + (SUM_W'(1) << code_i);

  for (genvar p = 0; p < NUM_PAGES; p++) begin : g_page
    assign mask_o[p] = (SUM_W'(p) >= start_i) && (SUM_W'(p) < end_excl);
  end

endmodule

// File: rtl/pgalloc_occ_map.sv
module pgalloc_occ_map #(
  parameter int NUM_PAGES  = 128,
  parameter int RESV_PAGES = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 grant_en_i,
  input  logic [NUM_PAGES-1:0] grant_mask_i,
  input  logic                 rel_en_i,
  input  logic [NUM_PAGES-1:0] rel_mask_i,
  output logic [NUM_PAGES-1:0] map_o
);

  localparam logic [NUM_PAGES-1:0] RESV_MASK =
    (NUM_PAGES'(1) << RESV_PAGES) - NUM_PAGES'(1);

  logic [NUM_PAGES-1:0] map_q, map_d;
  logic [NUM_PAGES-1:0] clr_mask, set_mask;

  always_comb begin
    clr_mask = rel_en_i   ? (rel_mask_i & ~RESV_MASK) : '0;
    set_mask = grant_en_i ? grant_mask_i : '0;
    map_d    = (map_q & ~clr_mask) | set_mask | RESV_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      map_q <= RESV_MASK;
    end else if (grant_en_i || rel_en_i) begin
      map_q <= map_d;
    end
  end

  assign map_o = map_q;

  AST_GRANT_WAS_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    grant_en_i |-> ((map_q & grant_mask_i) == '0)); // R6

  AST_REL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    rel_en_i |=> ((map_q & $past(rel_mask_i & ~RESV_MASK &
                                 ~(grant_en_i ? grant_mask_i : '0))) == '0)); // R8

endmodule

// File: rtl/pgalloc_search.sv
module pgalloc_search
  import pgalloc_pkg::*;
#(
  parameter int NUM_PAGES  = 128,
  parameter int PAGE_WORDS = 16,
  parameter int MAX_CODE   = 3,
  parameter int RESV_PAGES = 4,
  parameter int PAGE_W     = 7,
  parameter int CODE_W     = 2,
  parameter int SUM_W      = 8,
  parameter int LEN_W      = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_i,
  input  logic [LEN_W-1:0]     req_words_i,
  input  logic [NUM_PAGES-1:0] map_i,
  input  logic [NUM_PAGES-1:0] cand_mask_i,
  output logic [SUM_W-1:0]     cand_o,
  output logic [CODE_W-1:0]    code_o,
  output logic                 grant_en_o,
  output logic                 busy_o,
  output logic                 done_o,
  output logic [1:0]           err_o,
  output logic [PAGE_W-1:0]    start_page_o
);

  pga_state_e        state_q, state_d;
  logic [SUM_W-1:0]  cand_q, cand_d;
  logic [CODE_W-1:0] code_q, code_d;
  logic              done_q, done_d;
  pga_err_e          err_q, err_d;
  logic [PAGE_W-1:0] start_q, start_d;

  logic              len_ok;
  logic [CODE_W-1:0] len_code;
  logic [SUM_W:0]    cand_end;
  logic              fits;
  logic              free_run;

  always_comb begin
    len_ok   = 1'b0;
    len_code = '0;
    for (int c = 0; c <= MAX_CODE; c++) begin
      if (req_words_i == LEN_W'(PAGE_WORDS << c)) begin
        len_ok   = 1'b1;
        len_code = CODE_W'(c);
      end
    end
  end

  assign cand_end = {1'b0, cand_q} + ((SUM_W + 1)'(1) << code_q);
  assign fits     = cand_end <= (SUM_W + 1)'(NUM_PAGES);
  assign free_run = (map_i & cand_mask_i) == '0;

  always_comb begin
    state_d    = state_q;
    cand_d     = cand_q;
    code_d     = code_q;
    done_d     = 1'b0;
    err_d      = err_q;
    start_d    = start_q;
    grant_en_o = 1'b0;
    unique case (state_q)
      PGA_IDLE: begin
        if (req_i) begin
          if (len_ok) begin
            state_d = PGA_SEARCH;
            cand_d  = '0;
            code_d  = len_code;
          end else begin
            done_d  = 1'b1;
            err_d   = PGA_BADLEN;
            start_d = '0;
          end
        end
      end
      PGA_SEARCH: begin
        if (!fits) begin
          state_d = PGA_IDLE;
          done_d  = 1'b1;
          err_d   = PGA_NOSPACE;
          start_d = '0;
        end else if (free_run) begin
          state_d    = PGA_IDLE;
          done_d     = 1'b1;
          err_d      = PGA_OK;
          start_d    = cand_q[PAGE_W-1:0];
          grant_en_o = 1'b1;
        end else begin
          cand_d = cand_q + SUM_W'(1);
        end
      end
      default: state_d = PGA_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PGA_IDLE;
      cand_q  <= '0;
      code_q  <= '0;
      done_q  <= 1'b0;
      err_q   <= PGA_OK;
      start_q <= '0;
    end else begin
      state_q <= state_d;
      cand_q  <= cand_d;
      code_q  <= code_d;
      done_q  <= done_d;
      err_q   <= err_d;
      start_q <= start_d;
    end
  end

  assign cand_o       = cand_q;
  assign code_o       = code_q;
  assign busy_o       = (state_q == PGA_SEARCH);
  assign done_o       = done_q;
  assign err_o        = err_q;
  assign start_page_o = start_q;

  AST_GRANT_NOT_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && err_q == PGA_OK) |-> (start_q >= PAGE_W'(RESV_PAGES))); // R7

  AST_GRANT_FITS: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && err_q == PGA_OK) |->
      (({1'b0, start_q} + ((PAGE_W + 1)'(1) << code_q)) <= (PAGE_W + 1)'(NUM_PAGES))); // R5

  AST_CAND_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> (cand_q == $past(cand_q) + SUM_W'(1))); // R4

  AST_BUSY_ENDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> done_q); // R4

endmodule

// File: rtl/pgalloc_top.sv
module pgalloc_top #(
  parameter int NUM_PAGES  = 128,
  parameter int PAGE_WORDS = 16,
  parameter int MAX_CODE   = 3,
  parameter int RESV_PAGES = 4,
  parameter int PAGE_W     = $clog2(NUM_PAGES),
  parameter int CODE_W     = $clog2(MAX_CODE + 1),
  parameter int LEN_W      = $clog2(PAGE_WORDS << MAX_CODE) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic [LEN_W-1:0]  req_words_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [1:0]        err_o,
  output logic [PAGE_W-1:0] start_page_o,
  input  logic              rel_i,
  input  logic [PAGE_W-1:0] rel_page_i,
  input  logic [CODE_W-1:0] rel_code_i
);

  localparam int SUM_W = PAGE_W + 1;

  logic [NUM_PAGES-1:0] map;
  logic [NUM_PAGES-1:0] cand_mask;
  logic [NUM_PAGES-1:0] rel_mask;
  logic [SUM_W-1:0]     cand;
  logic [CODE_W-1:0]    code;
  logic                 grant_en;

  pgalloc_search #(
    .NUM_PAGES (NUM_PAGES),
    .PAGE_WORDS(PAGE_WORDS),
    .MAX_CODE  (MAX_CODE),
    .RESV_PAGES(RESV_PAGES),
    .PAGE_W    (PAGE_W),
    .CODE_W    (CODE_W),
    .SUM_W     (SUM_W),
    .LEN_W     (LEN_W)
  ) u_search (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_i       (req_i),
    .req_words_i (req_words_i),
    .map_i       (map),
    .cand_mask_i (cand_mask),
    .cand_o      (cand),
    .code_o      (code),
    .grant_en_o  (grant_en),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .err_o       (err_o),
    .start_page_o(start_page_o)
  );

  pgalloc_run_mask #(
    .NUM_PAGES(NUM_PAGES),
    .CODE_W   (CODE_W),
    .SUM_W    (SUM_W)
  ) u_cand_mask (
    .start_i(cand),
    .code_i (code),
    .mask_o (cand_mask)
  );

  pgalloc_run_mask #(
    .NUM_PAGES(NUM_PAGES),
    .CODE_W   (CODE_W),
    .SUM_W    (SUM_W)
  ) u_rel_mask (
    .start_i({1'b0, rel_page_i}),
    .code_i (rel_code_i),
    .mask_o (rel_mask)
  );

  pgalloc_occ_map #(
    .NUM_PAGES (NUM_PAGES),
    .RESV_PAGES(RESV_PAGES)
  ) u_occ_map (
    .clk         (clk),
    .rst_n       (rst_n),
    .grant_en_i  (grant_en),
    .grant_mask_i(cand_mask),
    .rel_en_i    (rel_i),
    .rel_mask_i  (rel_mask),
    .map_o       (map)
  );

endmodule

// File: tb/pgalloc_top_tb_top.sv
module pgalloc_top_tb_top;

  logic       clk;
  logic       rst_n;
  logic       req;
  logic [7:0] req_words;
  logic       busy;
  logic       done;
  logic [1:0] err;
  logic [6:0] page;
  logic       rel;
  logic [6:0] rel_page;
  logic [1:0] rel_code;

  int checks = 0;
  int errors = 0;

  pgalloc_top dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_i       (req),
    .req_words_i (req_words),
    .busy_o      (busy),
    .done_o      (done),
    .err_o       (err),
    .start_page_o(page),
    .rel_i       (rel),
    .rel_page_i  (rel_page),
    .rel_code_i  (rel_code)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wait_done(input int n0, output logic [1:0] e, output logic [6:0] pg,
                           output int lat);
    int n = n0;
    bit seen = 0;
    e = 2'b11; pg = '0; lat = -1;
    while (!seen && n < 400) begin
      if (done) begin
        seen = 1; lat = n; e = err; pg = page;
      end else begin
        @(negedge clk);
        n++;
      end
    end
  endtask

  task automatic do_req(input logic [7:0] words, output logic [1:0] e,
                        output logic [6:0] pg, output int lat);
    @(negedge clk);
    req = 1'b1; req_words = words;
    @(negedge clk);
    req = 1'b0;
    wait_done(1, e, pg, lat);
  endtask

  task automatic expect_grant(input logic [7:0] words, input int exp_pg, input string tag);
    logic [1:0] e; logic [6:0] pg; int lat;
    do_req(words, e, pg, lat);
    chk(e == 2'b00, {tag, " code"}, int'(e), 0);
    chk(int'(pg) == exp_pg, {tag, " page"}, int'(pg), exp_pg);
    chk(lat == exp_pg + 2, {tag, " R4 latency"}, lat, exp_pg + 2);
  endtask

  task automatic expect_err(input logic [7:0] words, input logic [1:0] code,
                            input int exp_lat, input string tag);
    logic [1:0] e; logic [6:0] pg; int lat;
    do_req(words, e, pg, lat);
    chk(e == code, {tag, " code"}, int'(e), int'(code));
    chk(lat == exp_lat, {tag, " latency"}, lat, exp_lat);
  endtask

  task automatic do_release(input logic [6:0] pg, input logic [1:0] code);
    @(negedge clk);
    rel = 1'b1; rel_page = pg; rel_code = code;
    @(negedge clk);
    rel = 1'b0;
  endtask

  task automatic t_reset();
    chk(busy == 1'b0, "R1 busy after reset", int'(busy), 0);
    chk(done == 1'b0, "R1 done after reset", int'(done), 0);
    expect_grant(8'd16, 4, "R1 first grant");
  endtask

  task automatic t_first_fit();
    expect_grant(8'd32, 5, "R3 unaligned 2-page");
    expect_grant(8'd16, 7, "R3 next 1-page");
  endtask

  task automatic t_badlen();
    expect_err(8'd48, 2'b01, 1, "R2 length 48");
    expect_err(8'd0, 2'b01, 1, "R2 length 0");
    expect_err(8'd255, 2'b01, 1, "R2 length 255");
    expect_grant(8'd16, 8, "R2 map unchanged after bad length");
  endtask

  task automatic t_release();
    do_release(7'd5, 2'd1);
    expect_grant(8'd16, 5, "R8 freed page 5");
    expect_grant(8'd16, 6, "R8 freed page 6");
    expect_grant(8'd16, 9, "R8 pages 7,8 still used");
  endtask

  task automatic t_lengths();
    expect_grant(8'd64, 10, "R2 4-page");
    expect_grant(8'd128, 14, "R2 8-page");
    expect_grant(8'd16, 22, "R6 after 8-page");
  endtask

  task automatic t_reserved();
    do_release(7'd0, 2'd3);
    expect_grant(8'd32, 4, "R7 release over reserved frees 4..5");
    expect_grant(8'd32, 6, "R7 release over reserved frees 6..7");
    expect_grant(8'd16, 23, "R7 reserved pages kept");
  endtask

  task automatic t_busy_ignore();
    int dones = 0;
    int first_pg = -1;
    @(negedge clk);
    req = 1'b1; req_words = 8'd16;
    @(negedge clk);
    req_words = 8'd128;
    chk(busy == 1'b1, "R4 busy during search", int'(busy), 1);
    @(negedge clk);
    req = 1'b0;
    for (int i = 0; i < 60; i++) begin
      if (done) begin
        dones++;
        if (first_pg < 0) first_pg = int'(page);
      end
      @(negedge clk);
    end
    chk(dones == 1, "R9 single completion", dones, 1);
    chk(first_pg == 24, "R9 first request page", first_pg, 24);
    chk(busy == 1'b0, "R9 idle after", int'(busy), 0);
    expect_grant(8'd16, 25, "R9 ignored request allocated nothing");
  endtask

  task automatic t_rel_during();
    logic [1:0] e; logic [6:0] pg; int lat;
    @(negedge clk);
    req = 1'b1; req_words = 8'd128;
    @(negedge clk);
    req = 1'b0;
    rel = 1'b1; rel_page = 7'd4; rel_code = 2'd3;
    @(negedge clk);
    rel = 1'b0;
    wait_done(2, e, pg, lat);
    chk(e == 2'b00, "R10 code", int'(e), 0);
    chk(pg == 7'd4, "R10 page sees mid-search release", int'(pg), 4);
    chk(lat == 6, "R10 latency", lat, 6);
  endtask

  task automatic t_nospace();
    for (int i = 0; i < 12; i++) expect_grant(8'd128, 26 + 8 * i, "R6 fill 8-page");
    expect_grant(8'd64, 122, "R6 fill 4-page");
    expect_grant(8'd32, 126, "R6 fill 2-page");
    expect_err(8'd16, 2'b10, 130, "R5 full 1-page");
    expect_err(8'd128, 2'b10, 123, "R5 full 8-page");
    do_release(7'd100, 2'd0);
    expect_err(8'd32, 2'b10, 129, "R5 hole too small");
    expect_grant(8'd16, 100, "R5 failed request changed nothing");
  endtask

  initial begin
    rst_n = 1'b0; req = 1'b0; req_words = '0;
    rel = 1'b0; rel_page = '0; rel_code = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_first_fit();
    t_badlen();
    t_release();
    t_lengths();
    t_reserved();
    t_busy_ignore();
    t_rel_during();
    t_nospace();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual %0d expected %0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule